// File: doc/BRIEF.md
# Inter-Core Interrupt Signalling Unit

This block lets any core in a cluster of up to `NUM_CORES` cores raise an interrupt on any other core. Each core owns one command lane into the unit. A lane carries a command code and a core-number operand, and the lane index identifies the issuing core. Each lane has its own 32-bit readback register, which holds the result of the last read-type command issued on that lane.

Every target core holds a pending vector with one bit per sender. Requests from different senders to one target merge onto a single interrupt line. That line stays high until the target has acknowledged every sender bit. Software on the target asks which senders are pending, then acknowledges each sender separately. A sender can first ask whether the target already has something pending, and skip the request if it does.

Top module: `xci_unit`

## Requirements
- R1: A send command (opcode 2'b00) on lane s with operand t, where t < NUM_CORES and t != s, sets sender bit s in target t's pending vector. `irq_o[t]` rises on the cycle after the command edge and not before it.
- R2: A send command whose operand equals the issuing lane's own index has no effect on any pending vector or interrupt line.
- R3: A send command whose operand is NUM_CORES or above has no effect.
- R4: A status query (opcode 2'b01) with operand t loads the lane's readback with 1 if target t has any sender bit pending, and with 0 otherwise. An operand of NUM_CORES or above reads 0. The value appears one cycle after the command.
- R5: A source query (opcode 2'b10) loads the lane's readback with the issuing core's pending vector. Bit s of that vector is sender s, and all bits from NUM_CORES upward are zero.
- R6: Requests from several senders to one target coalesce onto one interrupt line, and the source query then shows more than one bit.
- R7: An acknowledge (opcode 2'b11) with operand s on lane t clears only sender bit s of target t's pending vector.
- R8: `irq_o[t]` stays high while any bit of target t's pending vector is set, and falls on the cycle after the last bit is acknowledged.
- R9: When a send sets a bit and an acknowledge clears the same bit in the same cycle, the bit stays set.
- R10: While `rst_ni` is low, all pending vectors, interrupt lines and readback registers are zero.
- R11: Send and acknowledge commands, and idle cycles, leave a lane's readback unchanged. An acknowledge with an operand of NUM_CORES or above changes no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | NUM_CORES | One command strobe per core lane |
| cmd_op_i | input | 2*NUM_CORES | Command code per lane: 0 send, 1 status query, 2 source query, 3 acknowledge |
| cmd_arg_i | input | ARG_W*NUM_CORES | Core-number operand per lane |
| rdata_o | output | 32*NUM_CORES | Readback register per lane |
| irq_o | output | NUM_CORES | Interrupt line per target core |

## Verification
A wrong pending bit shows up on `irq_o` on the next cycle, but only when it is the last bit still set for its target. A wrong bit behind another pending sender shows up only in a source-query readback, one cycle after the query. The bench therefore reads the source vector after every acknowledge, as well as watching the interrupt lines. A lost collision rule, or a set that was accepted for the issuing core itself, makes a later source query return the wrong pattern.

// File: rtl/xci_pkg.sv
package xci_pkg;
  localparam int RB_W = 32;

  typedef enum logic [1:0] {
    OP_SEND  = 2'd0,
    OP_QUERY = 2'd1,
    OP_WHO   = 2'd2,
    OP_ACK   = 2'd3
  } xci_op_e;
endpackage

// File: rtl/xci_decode.sv
module xci_decode
  import xci_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ARG_W     = 8,
  parameter int LANE      = 0
) (
  input  logic                 valid_i,
  input  logic [1:0]           op_i,
  input  logic [ARG_W-1:0]     arg_i,
  output logic [NUM_CORES-1:0] set_o,   // bit t: raise sender LANE at target t
  output logic [NUM_CORES-1:0] clr_o,   // bit s: clear sender s at target LANE
  output logic                 query_o,
  output logic                 who_o
);
  logic is_send, is_ack;

  assign is_send = valid_i && (xci_op_e'(op_i) == OP_SEND);
  assign is_ack  = valid_i && (xci_op_e'(op_i) == OP_ACK);
  assign query_o = valid_i && (xci_op_e'(op_i) == OP_QUERY);
  assign who_o   = valid_i && (xci_op_e'(op_i) == OP_WHO);

  always_comb begin
    set_o = '0;
    clr_o = '0;
    for (int k = 0; k < NUM_CORES; k++) begin
      set_o[k] = is_send && (int'(arg_i) == k) && (k != LANE);
      clr_o[k] = is_ack  && (int'(arg_i) == k);
    end
  end
endmodule

// File: rtl/xci_pend_matrix.sv
module xci_pend_matrix #(
  parameter int NUM_CORES = 4
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [NUM_CORES-1:0][NUM_CORES-1:0]   set_i,   // [target][sender]
  input  logic [NUM_CORES-1:0][NUM_CORES-1:0]   clr_i,   // [target][sender]
  output logic [NUM_CORES-1:0][NUM_CORES-1:0]   pend_o,
  output logic [NUM_CORES-1:0]                  irq_o
);
  logic [NUM_CORES-1:0][NUM_CORES-1:0] pend_q;
  logic [NUM_CORES-1:0][NUM_CORES-1:0] clr_only;

  always_comb begin
    for (int t = 0; t < NUM_CORES; t++) clr_only[t] = clr_i[t] & ~set_i[t];
  end

  // set wins over clear on the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else begin
      for (int t = 0; t < NUM_CORES; t++)
        pend_q[t] <= set_i[t] | (pend_q[t] & ~clr_i[t]);
    end
  end

  assign pend_o = pend_q;

  for (genvar t = 0; t < NUM_CORES; t++) begin : g_irq
    assign irq_o[t] = |pend_q[t];

    // R1 R9
    set_sticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[t] != '0) |=> ((pend_q[t] & $past(set_i[t])) == $past(set_i[t])));

    // R7
    clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_only[t] != '0) |=> ((pend_q[t] & $past(clr_only[t])) == '0));

    // R8
    irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_o[t]) |-> $past(clr_i[t] != '0));
  end
endmodule

// File: rtl/xci_readback.sv
module xci_readback
  import xci_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ARG_W     = 8,
  parameter int LANE      = 0
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                query_i,
  input  logic                                who_i,
  input  logic [ARG_W-1:0]                    arg_i,
  input  logic [NUM_CORES-1:0][NUM_CORES-1:0] pend_i,
  output logic [RB_W-1:0]                     rdata_o
);
  logic [RB_W-1:0] rd_q, rd_d;
  logic            hit;

  always_comb begin
    hit = 1'b0;
    for (int t = 0; t < NUM_CORES; t++)
      if (int'(arg_i) == t) hit = |pend_i[t];
  end

  always_comb begin
    rd_d = rd_q;
    if (who_i) begin
      rd_d = '0;
      rd_d[NUM_CORES-1:0] = pend_i[LANE];
    end else if (query_i) begin
      rd_d = RB_W'(hit);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= rd_d;
  end

  assign rdata_o = rd_q;

  // R4
  query_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (query_i && !who_i) |=> (rd_q[RB_W-1:1] == '0));

  // R11
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(query_i || who_i) |=> $stable(rd_q));
endmodule

// File: rtl/xci_unit.sv
module xci_unit
  import xci_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ARG_W     = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_CORES-1:0]      cmd_valid_i,
  input  logic [2*NUM_CORES-1:0]    cmd_op_i,
  input  logic [ARG_W*NUM_CORES-1:0] cmd_arg_i,
  output logic [RB_W*NUM_CORES-1:0] rdata_o,
  output logic [NUM_CORES-1:0]      irq_o
);
  logic [NUM_CORES-1:0][NUM_CORES-1:0] lane_set;  // [lane][target]
  logic [NUM_CORES-1:0][NUM_CORES-1:0] lane_clr;  // [lane][sender]
  logic [NUM_CORES-1:0][NUM_CORES-1:0] set_mx, pend;
  logic [NUM_CORES-1:0]                query, who;

  for (genvar l = 0; l < NUM_CORES; l++) begin : g_lane
    logic [1:0]       op;
    logic [ARG_W-1:0] arg;
    assign op  = cmd_op_i[2*l +: 2];
    assign arg = cmd_arg_i[ARG_W*l +: ARG_W];

    xci_decode #(.NUM_CORES(NUM_CORES), .ARG_W(ARG_W), .LANE(l)) u_dec (
      .valid_i (cmd_valid_i[l]),
      .op_i    (op),
      .arg_i   (arg),
      .set_o   (lane_set[l]),
      .clr_o   (lane_clr[l]),
      .query_o (query[l]),
      .who_o   (who[l])
    );

    xci_readback #(.NUM_CORES(NUM_CORES), .ARG_W(ARG_W), .LANE(l)) u_rb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .query_i (query[l]),
      .who_i   (who[l]),
      .arg_i   (arg),
      .pend_i  (pend),
      .rdata_o (rdata_o[RB_W*l +: RB_W])
    );

    // R2
    no_self_send_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_i[l] && op == OP_SEND && int'(arg) == l) |-> (lane_set[l] == '0));

    // R3
    range_send_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(arg) >= NUM_CORES) |-> (lane_set[l] == '0 && lane_clr[l] == '0));
  end

  // transpose: sender lane s raising target t lands at pend[t][s]
  always_comb begin
    for (int t = 0; t < NUM_CORES; t++)
      for (int s = 0; s < NUM_CORES; s++)
        set_mx[t][s] = lane_set[s][t];
  end

  xci_pend_matrix #(.NUM_CORES(NUM_CORES)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_mx),
    .clr_i  (lane_clr),
    .pend_o (pend),
    .irq_o  (irq_o)
  );
endmodule

// File: tb/xci_unit_test.sv
`timescale 1ns/1ps
module xci_unit_test;
  localparam int N = 4;
  localparam int AW = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [N-1:0]      cmd_valid_i = '0;
  logic [2*N-1:0]    cmd_op_i = '0;
  logic [AW*N-1:0]   cmd_arg_i = '0;
  logic [32*N-1:0]   rdata_o;
  logic [N-1:0]      irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  xci_unit #(.NUM_CORES(N), .ARG_W(AW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i),
    .cmd_op_i(cmd_op_i), .cmd_arg_i(cmd_arg_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [1:0]  lane;
    logic [1:0]  op;
    logic [7:0]  arg;
    logic [31:0] rd;
    logic [3:0]  irq;
    logic [3:0]  req;
  } vec_t;

  // op: 0 send, 1 status query, 2 source query, 3 ack
  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 8'd2, 32'h0, 4'b0100, 4'd1},   // R1 0->2
    '{2'd1, 2'd0, 8'd2, 32'h0, 4'b0100, 4'd6},   // R6 1->2 coalesce
    '{2'd3, 2'd1, 8'd2, 32'h1, 4'b0100, 4'd4},   // R4 target 2 pending
    '{2'd3, 2'd1, 8'd1, 32'h0, 4'b0100, 4'd4},   // R4 target 1 idle
    '{2'd2, 2'd2, 8'd0, 32'h3, 4'b0100, 4'd5},   // R5 R6 senders 0,1
    '{2'd2, 2'd0, 8'd2, 32'h3, 4'b0100, 4'd2},   // R2 self send
    '{2'd2, 2'd2, 8'd0, 32'h3, 4'b0100, 4'd2},   // R2 vector unchanged
    '{2'd0, 2'd0, 8'd4, 32'h0, 4'b0100, 4'd3},   // R3 out of range
    '{2'd1, 2'd1, 8'd9, 32'h0, 4'b0100, 4'd4},   // R4 out-of-range query
    '{2'd2, 2'd3, 8'd0, 32'h3, 4'b0100, 4'd11},  // R11 ack keeps readback
    '{2'd2, 2'd2, 8'd0, 32'h2, 4'b0100, 4'd7},   // R7 only sender 0 gone
    '{2'd2, 2'd3, 8'd1, 32'h2, 4'b0000, 4'd8},   // R8 last ack drops irq
    '{2'd2, 2'd2, 8'd0, 32'h0, 4'b0000, 4'd8},   // R8 vector empty
    '{2'd3, 2'd0, 8'd0, 32'h0, 4'b0001, 4'd1},   // R1 3->0
    '{2'd0, 2'd2, 8'd0, 32'h8, 4'b0001, 4'd5},   // R5 sender 3
    '{2'd0, 2'd3, 8'd5, 32'h8, 4'b0001, 4'd11},  // R11 ack out of range
    '{2'd3, 2'd1, 8'd0, 32'h1, 4'b0001, 4'd4}    // R4 target 0 pending
  };

  task automatic check(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put(input int lane, input logic [1:0] op, input logic [7:0] arg);
    cmd_valid_i[lane] = 1'b1;
    cmd_op_i[2*lane +: 2] = op;
    cmd_arg_i[AW*lane +: AW] = arg;
  endtask

  task automatic step();
    @(negedge clk_i);
    cmd_valid_i = '0;
  endtask

  function automatic logic [31:0] rd(input int lane);
    return rdata_o[32*lane +: 32];
  endfunction

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check(irq_o == '0, 10, "irq in reset", 32'(irq_o), 0);
    check(rdata_o == '0, 10, "readback in reset", rdata_o[31:0], 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      put(VECS[i].lane, VECS[i].op, VECS[i].arg);
      step();
      check(rd(VECS[i].lane) == VECS[i].rd, VECS[i].req, $sformatf("vec %0d rdata", i),
            rd(VECS[i].lane), VECS[i].rd);
      check(irq_o == VECS[i].irq, VECS[i].req, $sformatf("vec %0d irq", i),
            32'(irq_o), 32'(VECS[i].irq));
    end

    // R1 irq unchanged before the command edge
    put(2, 2'd0, 8'd1);
    #1;
    check(irq_o == 4'b0001, 1, "irq before edge", 32'(irq_o), 32'h1);
    step();
    check(irq_o == 4'b0011, 1, "irq after edge", 32'(irq_o), 32'h3);

    // R9 send and ack on the same bit: first with bit clear, then with bit set
    put(1, 2'd0, 8'd0); put(0, 2'd3, 8'd1);
    step();
    put(1, 2'd0, 8'd0); put(0, 2'd3, 8'd1);
    step();
    put(0, 2'd2, 8'd0);
    step();
    check(rd(0) == 32'hA, 9, "collision keeps bit", rd(0), 32'hA);

    // R8 line stays while one sender remains
    put(0, 2'd3, 8'd1);
    step();
    check(irq_o[0] == 1'b1, 8, "irq with one left", 32'(irq_o[0]), 1);
    put(0, 2'd3, 8'd3);
    step();
    check(irq_o[0] == 1'b0, 8, "irq after last ack", 32'(irq_o[0]), 0);

    // R10 reset mid-run clears everything
    put(1, 2'd2, 8'd0);
    step();
    check(rd(1) == 32'h4, 5, "lane1 sources", rd(1), 32'h4);
    rst_ni = 1'b0;
    #1;
    check(irq_o == '0, 10, "irq after reset", 32'(irq_o), 0);
    check(rdata_o == '0, 10, "readback after reset", rd(1), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule